// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a register-mapped watchdog. Software loads a 64-bit timeout period and sets up the enable controls. It then arms the watchdog by writing two fixed 16-bit keys, one after the other, into the upper half of the watchdog control word. While armed, a 64-bit up-counter advances once per clock. Software keeps the system alive by writing the same two-key pair again, which zeroes the counter. If the counter ever equals the period, a sticky expiry flag is set and a one-clock reset request leaves the block.

When the first key is accepted, every configuration register is frozen until a system reset. Only the key field and the write-one-to-clear expiry flag remain writable. A stray or half-finished key write cannot stop or reconfigure a running watchdog.

Top module: `kwdt_top`

## Requirements
- R1: After reset the state is idle and every register reads 0, except the identity word at 0x00, which reads 32'h4B57_0100. In idle, configuration writes take effect.
- R2: Register map, byte offsets: 0x10 counter low, 0x14 counter high, 0x18 period low, 0x1C period high, 0x20 timer control (run mode in bits 7:6, other bits read 0), 0x24 global control (bit 0 releases the low half, bit 1 releases the high half, bits 3:2 select the mode, other bits read 0), 0x28 watchdog control (bit 14 enable, bit 15 expiry flag, bits 31:16 key, read as 0). Reads return the live values. Offset 0x04 and unmapped offsets read 0 and ignore writes.
- R3: In idle, a write to 0x28 with key 16'hA5C6 and bit 14 set moves the block to pre-active. A following write of key 16'hDA7E moves it to active.
- R4: Outside idle, writes to 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 are ignored. The enable bit of 0x28 is also ignored.
- R5: The counter adds 1 on each clock edge only when all of these hold: the state is active or service, global control bits 1:0 are both 1, global control bits 3:2 equal 2, and the run mode is nonzero.
- R6: In active, key 16'hA5C6 moves the block to service. In service, key 16'hDA7E zeroes the 64-bit counter and returns the block to active.
- R7: A key write that is out of sequence, or any key value other than the two keys, leaves the state unchanged and does not clear the counter.
- R8: In active or service, when the counter equals {period high, period low} at a clock edge, that edge sets the expiry flag. If the flag was clear, the same edge also raises `wdog_bite` for exactly one cycle.
- R9: The expiry flag stays set until a write to 0x28 with bit 15 set, or until a system reset. A set event in the same cycle wins over the clear.
- R10: If the counter matches the period on the same edge that completes a service, the expiry fires and the counter still goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| reg_addr | input | AW (8) | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr`, combinational |
| wdog_bite | output | 1 | One-cycle reset request on expiry |

## Verification
Service completion and period match can land on the same clock edge. This happens when the second service key is written in exactly the cycle in which the counter equals the period. The bench provokes it by preloading the counter two below the period while idle, then arming, entering service and timing the second key to that cycle. The case is judged correct when, in the next cycle, `wdog_bite` is high, the flag reads back as set and the counter reads back as zero.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_PRE  = 2'd1,
    WD_RUN  = 2'd2,
    WD_SVC  = 2'd3
  } wd_state_e;

  localparam logic [15:0] KEY_ARM = 16'hA5C6;
  localparam logic [15:0] KEY_GO  = 16'hDA7E;

  localparam int unsigned OFS_ID     = 'h00;
  localparam int unsigned OFS_CNT_LO = 'h10;
  localparam int unsigned OFS_CNT_HI = 'h14;
  localparam int unsigned OFS_PER_LO = 'h18;
  localparam int unsigned OFS_PER_HI = 'h1C;
  localparam int unsigned OFS_TMR    = 'h20;
  localparam int unsigned OFS_GLB    = 'h24;
  localparam int unsigned OFS_WDC    = 'h28;

  localparam int unsigned EN_BIT   = 14;
  localparam int unsigned FLAG_BIT = 15;
  localparam logic [1:0]  GLB_WDOG_MODE = 2'd2;

  // next state of the key handshake for one write of the key field
  function automatic wd_state_e key_step(wd_state_e s, logic [15:0] key, logic en);
    wd_state_e n;
    n = s;
    case (s)
      WD_IDLE: if (key == KEY_ARM && en) n = WD_PRE;
      WD_PRE:  if (key == KEY_GO)        n = WD_RUN;
      WD_RUN:  if (key == KEY_ARM)       n = WD_SVC;
      WD_SVC:  if (key == KEY_GO)        n = WD_RUN;
      default: n = s;
    endcase
    return n;
  endfunction

  function automatic logic is_live(wd_state_e s);
    return (s == WD_RUN) || (s == WD_SVC);
  endfunction

endpackage

// File: rtl/kwdt_keyfsm.sv
module kwdt_keyfsm
  import kwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [15:0] key,
  input  logic        en_bit,
  output wd_state_e   state,
  output logic        arm_evt,
  output logic        svc_done
);

  wd_state_e st_q, st_n;

  assign st_n     = key_wr ? key_step(st_q, key, en_bit) : st_q;
  assign arm_evt  = (st_q == WD_IDLE) && (st_n == WD_PRE);
  assign svc_done = (st_q == WD_SVC) && (st_n == WD_RUN);
  assign state    = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WD_IDLE;
    else        st_q <= st_n;
  end

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [DW-1:0]   ld_val,
  input  logic            run,
  input  logic            clr,
  input  logic [2*DW-1:0] period,
  output logic [2*DW-1:0] cnt,
  output logic            match
);

  localparam int unsigned CW = 2 * DW;

  function automatic logic [CW-1:0] advance(logic [CW-1:0] c, logic go);
    return c + {{(CW-1){1'b0}}, go};
  endfunction

  function automatic logic at_limit(logic [CW-1:0] c, logic [CW-1:0] p);
    return c == p;
  endfunction

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (ld_lo) cnt_q[DW-1:0] <= ld_val;
    else if (ld_hi) cnt_q[CW-1:DW] <= ld_val;
    else            cnt_q <= advance(cnt_q, run);
  end

  assign cnt   = cnt_q;
  assign match = at_limit(cnt_q, period);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  parameter logic [DW-1:0] ID_VALUE = 32'h4B57_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          wdog_bite
);

  localparam int unsigned CW      = 2 * DW;
  localparam int unsigned KEY_LSB = DW - 16;

  wd_state_e     st;
  logic          arm_evt, svc_done, locked, live, hit, run;
  logic [CW-1:0] per_q, cnt;
  logic [1:0]    tmr_mode_q;
  logic [3:0]    glb_q;
  logic          en_q, flag_q, bite_q, match;

  logic wr_cnt_lo, wr_cnt_hi, wr_per_lo, wr_per_hi, wr_tmr, wr_glb, wr_wdc, w1c;

  assign wr_cnt_lo = reg_we && (reg_addr == AW'(OFS_CNT_LO));
  assign wr_cnt_hi = reg_we && (reg_addr == AW'(OFS_CNT_HI));
  assign wr_per_lo = reg_we && (reg_addr == AW'(OFS_PER_LO));
  assign wr_per_hi = reg_we && (reg_addr == AW'(OFS_PER_HI));
  assign wr_tmr    = reg_we && (reg_addr == AW'(OFS_TMR));
  assign wr_glb    = reg_we && (reg_addr == AW'(OFS_GLB));
  assign wr_wdc    = reg_we && (reg_addr == AW'(OFS_WDC));
  assign w1c       = wr_wdc && reg_wdata[FLAG_BIT];

  kwdt_keyfsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (wr_wdc),
    .key      (reg_wdata[DW-1:KEY_LSB]),
    .en_bit   (reg_wdata[EN_BIT]),
    .state    (st),
    .arm_evt  (arm_evt),
    .svc_done (svc_done)
  );

  assign locked = (st != WD_IDLE);
  assign live   = is_live(st);
  assign run    = live && glb_q[0] && glb_q[1] && (glb_q[3:2] == GLB_WDOG_MODE)
                  && (tmr_mode_q != 2'd0);
  assign hit    = live && match;

  kwdt_counter #(.DW(DW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_lo  (wr_cnt_lo && !locked),
    .ld_hi  (wr_cnt_hi && !locked),
    .ld_val (reg_wdata),
    .run    (run),
    .clr    (svc_done),
    .period (per_q),
    .cnt    (cnt),
    .match  (match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q      <= '0;
      tmr_mode_q <= '0;
      glb_q      <= '0;
      en_q       <= 1'b0;
    end else if (!locked) begin
      if (wr_per_lo) per_q[DW-1:0]  <= reg_wdata;
      if (wr_per_hi) per_q[CW-1:DW] <= reg_wdata;
      if (wr_tmr)    tmr_mode_q     <= reg_wdata[7:6];
      if (wr_glb)    glb_q          <= reg_wdata[3:0];
      if (wr_wdc)    en_q           <= reg_wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      bite_q <= 1'b0;
    end else begin
      bite_q <= hit && !flag_q;
      if (hit)      flag_q <= 1'b1;
      else if (w1c) flag_q <= 1'b0;
    end
  end

  assign wdog_bite = bite_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFS_ID):     reg_rdata = ID_VALUE;
      AW'(OFS_CNT_LO): reg_rdata = cnt[DW-1:0];
      AW'(OFS_CNT_HI): reg_rdata = cnt[CW-1:DW];
      AW'(OFS_PER_LO): reg_rdata = per_q[DW-1:0];
      AW'(OFS_PER_HI): reg_rdata = per_q[CW-1:DW];
      AW'(OFS_TMR):    reg_rdata[7:6] = tmr_mode_q;
      AW'(OFS_GLB):    reg_rdata[3:0] = glb_q;
      AW'(OFS_WDC): begin
        reg_rdata[EN_BIT]   = en_q;
        reg_rdata[FLAG_BIT] = flag_q;
      end
      default:         reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int unsigned CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bite,
  input logic          flag,
  input logic          hit,
  input logic          w1c,
  input logic          locked,
  input logic          per_wr,
  input logic [CW-1:0] per,
  input logic          svc_done,
  input logic [CW-1:0] cnt,
  input wd_state_e     st,
  input logic          arm_evt
);

  assert_bite_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> !bite);

  assert_bite_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bite |-> flag);

  assert_hit_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !w1c) |=> flag);

  assert_period_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && per_wr) |=> $stable(per));

  assert_service_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> (cnt == '0));

  assert_idle_needs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WD_IDLE && !arm_evt) |=> (st == WD_IDLE));

endmodule

bind kwdt_top kwdt_chk #(.CW(2 * DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bite     (wdog_bite),
  .flag     (flag_q),
  .hit      (hit),
  .w1c      (w1c),
  .locked   (locked),
  .per_wr   (wr_per_lo || wr_per_hi),
  .per      (per_q),
  .svc_done (svc_done),
  .cnt      (cnt),
  .st       (st),
  .arm_evt  (arm_evt)
);

// File: tb/kwdt_top_tb_top.sv
`timescale 1ns/1ps
module kwdt_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wdog_bite;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  kwdt_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wdog_bite (wdog_bite)
  );

  localparam logic [31:0] ID_EXP = 32'h4B57_0100;
  localparam logic [31:0] K_ARM  = 32'hA5C6_0000;
  localparam logic [31:0] K_GO   = 32'hDA7E_0000;
  localparam logic [31:0] EN     = 32'h0000_4000;
  localparam logic [31:0] FLG    = 32'h0000_8000;

  // {req, addr, we, wdata, expected read before the write}
  localparam int NV = 24;
  localparam logic [76:0] VEC [NV] = '{
    {4'd1,  8'h00, 1'b0, 32'h0,        ID_EXP},       // R1 identity
    {4'd1,  8'h24, 1'b1, 32'h0000_000B, 32'h0},       // R1 global zero
    {4'd1,  8'h20, 1'b1, 32'h0000_0080, 32'h0},       // R1 timer zero
    {4'd1,  8'h18, 1'b1, 32'h0000_0028, 32'h0},       // R1 period zero
    {4'd2,  8'h24, 1'b0, 32'h0,        32'h0000_000B}, // R2
    {4'd2,  8'h20, 1'b0, 32'h0,        32'h0000_0080}, // R2
    {4'd2,  8'h10, 1'b1, 32'h0000_0002, 32'h0},       // R2 preload
    {4'd5,  8'h10, 1'b0, 32'h0,        32'h0000_0002}, // R5 idle holds
    {4'd3,  8'h28, 1'b1, K_ARM | EN,   32'h0},        // R3 first key
    {4'd4,  8'h18, 1'b1, 32'h0000_0063, 32'h0000_0028}, // R4 locked write
    {4'd4,  8'h18, 1'b0, 32'h0,        32'h0000_0028}, // R4 ignored
    {4'd3,  8'h28, 1'b1, K_GO,         EN},           // R3 second key
    {4'd3,  8'h10, 1'b0, 32'h0,        32'h0000_0002}, // R3
    {4'd5,  8'h10, 1'b0, 32'h0,        32'h0000_0003}, // R5 counting
    {4'd7,  8'h28, 1'b1, K_GO,         EN},           // R7 stray key
    {4'd7,  8'h10, 1'b0, 32'h0,        32'h0000_0005}, // R7 no clear
    {4'd6,  8'h28, 1'b1, K_ARM,        EN},           // R6 enter service
    {4'd7,  8'h28, 1'b1, 32'h1234_0000, EN},          // R7 bad key
    {4'd6,  8'h28, 1'b1, K_GO,         EN},           // R6 finish service
    {4'd6,  8'h10, 1'b0, 32'h0,        32'h0},        // R6 cleared
    {4'd5,  8'h10, 1'b0, 32'h0,        32'h0000_0001}, // R5
    {4'd4,  8'h14, 1'b1, 32'h0000_0005, 32'h0},       // R4 locked high
    {4'd4,  8'h14, 1'b0, 32'h0,        32'h0},        // R4 ignored
    {4'd8,  8'h28, 1'b0, 32'h0,        EN}            // R8 no flag yet
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_step(input logic [7:0] a, input logic w, input logic [31:0] d,
                         output logic [31:0] rd, output logic b);
    @(negedge clk);
    reg_addr = a; reg_we = w; reg_wdata = d;
    #1;
    rd = reg_rdata; b = wdog_bite;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic b;
    bit seen;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      do_step(VEC[i][72:65], VEC[i][64], VEC[i][63:32], rd, b);
      n_chk++;
      if (rd !== VEC[i][31:0] || b !== 1'b0) begin
        n_fail++;
        $display("FAIL R%0d vector %0d got=%h exp=%h bite=%b", VEC[i][76:73], i, rd, VEC[i][31:0], b);
      end
    end

    // R8: expiry when the counter reaches 40; edge also advances it to 41
    seen = 1'b0;
    for (int k = 0; k < 100 && !seen; k++) begin
      do_step(8'h10, 1'b0, 32'h0, rd, b);
      if (b) begin
        seen = 1'b1;
        check("R8 count at bite", rd, 32'd41);
      end
    end
    check("R8 bite seen", {31'b0, seen}, 32'd1);
    do_step(8'h28, 1'b0, 32'h0, rd, b);
    check("R8 bite one cycle", {31'b0, b}, 32'd0);
    check("R8 flag set", rd, FLG | EN);
    do_step(8'h28, 1'b0, 32'h0, rd, b);
    check("R9 flag sticky", rd, FLG | EN);
    // R9 write-one clear; R4 enable bit 0 in this write is ignored
    do_step(8'h28, 1'b1, FLG, rd, b);
    do_step(8'h28, 1'b0, 32'h0, rd, b);
    check("R9 flag cleared, R4 enable kept", rd, EN);

    // R1 reset returns to idle with zeroed registers
    do_reset();
    do_step(8'h18, 1'b0, 32'h0, rd, b);
    check("R1 period after reset", rd, 32'h0);
    do_step(8'h28, 1'b0, 32'h0, rd, b);
    check("R1 control after reset", rd, 32'h0);
    do_step(8'h18, 1'b1, 32'h5, rd, b);
    do_step(8'h18, 1'b0, 32'h0, rd, b);
    check("R1 idle accepts writes", rd, 32'h5);
    do_step(8'h04, 1'b1, 32'hFFFF_FFFF, rd, b);
    do_step(8'h04, 1'b0, 32'h0, rd, b);
    check("R2 unmapped reads zero", rd, 32'h0);

    // R5 counting gated by the mode field of global control
    do_step(8'h20, 1'b1, 32'h80, rd, b);
    do_step(8'h24, 1'b1, 32'h3, rd, b);
    do_step(8'h28, 1'b1, K_ARM | EN, rd, b);
    do_step(8'h28, 1'b1, K_GO, rd, b);
    repeat (3) do_step(8'h10, 1'b0, 32'h0, rd, b);
    check("R5 wrong mode holds count", rd, 32'h0);

    // R10 service completion and period match on the same edge
    do_reset();
    do_step(8'h24, 1'b1, 32'hB, rd, b);
    do_step(8'h20, 1'b1, 32'h80, rd, b);
    do_step(8'h18, 1'b1, 32'd10, rd, b);
    do_step(8'h10, 1'b1, 32'd8, rd, b);
    do_step(8'h28, 1'b1, K_ARM | EN, rd, b);
    do_step(8'h28, 1'b1, K_GO, rd, b);
    do_step(8'h28, 1'b1, K_ARM, rd, b);
    do_step(8'h10, 1'b0, 32'h0, rd, b);
    check("R10 count before", rd, 32'd9);
    do_step(8'h28, 1'b1, K_GO, rd, b);
    check("R10 no early bite", {31'b0, b}, 32'd0);
    do_step(8'h10, 1'b0, 32'h0, rd, b);
    check("R10 counter cleared", rd, 32'd0);
    check("R10 bite fired", {31'b0, b}, 32'd1);
    do_step(8'h28, 1'b0, 32'h0, rd, b);
    check("R10 flag set", rd, FLG | EN);

    finish_run();
  end

endmodule